// File: doc/BRIEF.md
# Hot-Plug Slot Status Latch with Change Interrupt

This block watches the slot-status signals of six hot-plug slots. Each slot has four active-low inputs: two card-detect lines, a power-fault line and a chassis-switch line. All 24 inputs appear in one 32-bit status word. While a bit has no pending interrupt it shows the synchronised live level of its input. When an unmasked input changes in either direction, the bit freezes at the new level and the interrupt output rises. The bit stays frozen until software writes 1 to it. A second word, the mask, holds one suppression bit per input.

A 3-bit slot-count value sets how many slots are fitted. Each input of a slot above that count is replaced by the same input of the highest fitted slot, in all four groups. That replacement is made before change detection, so the mirrored bits also latch and interrupt unless they are masked.

Top module: `hp_intr_reg`

## Requirements
- R1: While reset is held, the status word (address 0) reads 0x00000000, the mask word (address 1) reads 0x3F3F3F3F and `irq` is 0.
- R2: Field placement is the same in both words. Bits 5:0 are the chassis switches, bits 13:8 the power faults, bits 21:16 card-detect B and bits 29:24 card-detect A. Within each field the lowest bit is slot 0. Bits 31:30, 23:22, 15:14 and 7:6 always read 0, and any other address reads 0.
- R3: A bit that is not pending reads the level of its input delayed by the two-stage synchroniser. Nothing is latched while that input is masked.
- R4: A change of an unmasked input, falling or rising, sets the bit pending on the cycle after the synchronised level changes. The bit latches the new level and `irq` goes to 1.
- R5: While a bit is pending and not being cleared, its read value stays at the latched level, whatever its input does.
- R6: Writing 1 to a status bit clears its pending state. Writing 0 leaves a pending bit pending with its latched value.
- R7: The mask word is read/write. A mask bit of 1 stops its input from becoming pending. Unmasked bits are not affected.
- R8: If the live input differs from the latched level when the bit is cleared, the bit reads live with `irq` low for one cycle. It then becomes pending again with the live level latched.
- R9: If a clear and a new synchronised change reach the same bit in the same cycle, the bit stays pending and latches the new level.
- R10: With slot count n (0 taken as 1, 6 or more meaning all slots), every bit of slot k ≥ n reports the input of slot n−1 in the same group. The bit's own input has no effect.
- R11: `irq` is 1 exactly when at least one status bit is pending. It stays 1 until the last pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_det_a_n | input | 6 | Card-detect A per slot, active low |
| card_det_b_n | input | 6 | Card-detect B per slot, active low |
| pwr_fault_n | input | 6 | Power fault per slot, active low |
| slot_switch_n | input | 6 | Chassis switch per slot, low when closed |
| slot_count | input | 3 | Number of fitted slots |
| reg_addr | input | 2 | Register select: 0 status, 1 mask |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_wdata | input | 32 | Write data (1 clears on status, value on mask) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt, OR of pending bits |

## Verification
The assertions assume that each change on a slot input lasts at least one clock after synchronisation. A pulse shorter than that can be lost between the two stages, and the rule that a change leads to a pending bit would then have nothing to check. They also assume `slot_count` changes only while the affected bits are masked, because a strap change looks like an input change on the mirrored bits. The bench drives every input on the falling edge and holds each level for four or more cycles. It changes the slot count only with the mask at all ones, so the stimulus stays inside both assumptions.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int HP_SLOTS  = 6;
    localparam int HP_GROUPS = 4;
    localparam int HP_FIELD  = 8;
    localparam int HP_CNT_W  = 3;
    localparam int HP_ADDR_W = 2;
    localparam int HP_REG_W  = 32;

    typedef enum logic [HP_ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1
    } hp_sel_e;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/hp_slot_mirror.sv
module hp_slot_mirror #(
    parameter int SLOTS  = 6,
    parameter int GROUPS = 4,
    parameter int CNT_W  = 3,
    localparam int N     = SLOTS * GROUPS
) (
    input  logic [N-1:0]     raw_in,
    input  logic [CNT_W-1:0] slot_count,
    output logic [N-1:0]     mirrored
);
    int last_slot;

    // highest fitted slot index, clamped to 0..SLOTS-1
    always_comb begin
        int n;
        n = {{(32-CNT_W){1'b0}}, slot_count};
        if (n < 1)     n = 1;
        if (n > SLOTS) n = SLOTS;
        last_slot = n - 1;
    end

    always_comb begin
        mirrored = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (k <= last_slot)
                    mirrored[g*SLOTS + k] = raw_in[g*SLOTS + k];
                else
                    mirrored[g*SLOTS + k] = raw_in[g*SLOTS + last_slot];
            end
        end
    end

endmodule

// File: rtl/hp_bit_latch.sv
module hp_bit_latch #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] live,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] hold
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] hold;
        logic [N-1:0] prev;
    } latch_t;

    latch_t st_d, st_q;

    logic [N-1:0] edge_seen;
    logic [N-1:0] stale;
    logic [N-1:0] open_bits;
    logic [N-1:0] trig;

    always_comb begin
        edge_seen = live ^ st_q.prev;
        // a just-cleared bit whose input moved away from the held level
        stale     = ~st_q.pend & (live ^ st_q.hold);
        // bits free to take a new event: idle, or being cleared this cycle
        open_bits = ~st_q.pend | clr;
        trig      = open_bits & ~mask & (edge_seen | stale);

        st_d      = st_q;
        st_d.prev = live;
        st_d.pend = trig | (st_q.pend & ~clr);
        st_d.hold = (trig & live)
                  | (~trig &  st_q.pend & st_q.hold)
                  | (~trig & ~st_q.pend & live);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign hold = st_q.hold;

    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.hold ^ $past(st_q.hold)) & $past(st_q.pend & ~clr)) == '0);

    assert_pend_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (~st_q.pend & $past(st_q.pend & ~clr)) == '0);

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & $past(mask & ~st_q.pend)) == '0);

    assert_change_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(~mask & (live ^ st_q.prev) & (~st_q.pend | clr)) & ~st_q.pend) == '0);

    assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & $past(st_q.pend & clr & ~(live ^ st_q.prev))) == '0);

endmodule

// File: rtl/hp_intr_reg.sv
module hp_intr_reg
    import hp_pkg::*;
#(
    parameter int SLOTS  = HP_SLOTS,
    parameter int GROUPS = HP_GROUPS,
    parameter int FIELD  = HP_FIELD,
    parameter int CNT_W  = HP_CNT_W,
    parameter int REG_W  = HP_REG_W,
    localparam int N     = SLOTS * GROUPS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOTS-1:0]     card_det_a_n,
    input  logic [SLOTS-1:0]     card_det_b_n,
    input  logic [SLOTS-1:0]     pwr_fault_n,
    input  logic [SLOTS-1:0]     slot_switch_n,
    input  logic [CNT_W-1:0]     slot_count,
    input  logic [HP_ADDR_W-1:0] reg_addr,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq
);
    // internal order: group 0 switch, 1 fault, 2 detect B, 3 detect A
    function automatic logic [REG_W-1:0] to_reg(input logic [N-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int g = 0; g < GROUPS; g++)
            for (int k = 0; k < SLOTS; k++)
                r[g*FIELD + k] = v[g*SLOTS + k];
        return r;
    endfunction

    function automatic logic [N-1:0] from_reg(input logic [REG_W-1:0] r);
        logic [N-1:0] v;
        for (int g = 0; g < GROUPS; g++)
            for (int k = 0; k < SLOTS; k++)
                v[g*SLOTS + k] = r[g*FIELD + k];
        return v;
    endfunction

    localparam logic [REG_W-1:0] USED_BITS = to_reg({N{1'b1}});

    typedef struct packed {
        logic [N-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N-1:0] raw_in, synced, live;
    logic [N-1:0] clr_bits, pend, hold, view;
    logic         wr_status, wr_mask;

    assign raw_in = {card_det_a_n, card_det_b_n, pwr_fault_n, slot_switch_n};

    hp_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    hp_slot_mirror #(.SLOTS(SLOTS), .GROUPS(GROUPS), .CNT_W(CNT_W)) u_mirror (
        .raw_in     (synced),
        .slot_count (slot_count),
        .mirrored   (live)
    );

    always_comb begin
        wr_status = reg_we && (reg_addr == SEL_STATUS);
        wr_mask   = reg_we && (reg_addr == SEL_MASK);
        clr_bits  = wr_status ? from_reg(reg_wdata) : '0;
        cfg_d     = cfg_q;
        if (wr_mask) cfg_d.mask = from_reg(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{mask: '1};
        else        cfg_q <= cfg_d;
    end

    hp_bit_latch #(.N(N)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .mask  (cfg_q.mask),
        .clr   (clr_bits),
        .pend  (pend),
        .hold  (hold)
    );

    assign view = (pend & hold) | (~pend & live);

    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = to_reg(view);
            SEL_MASK:   reg_rdata = to_reg(cfg_q.mask);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |pend;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED_BITS) == '0);

    assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (to_reg(pend) != '0));

endmodule

// File: tb/tb_hp_intr_reg.sv
module tb_hp_intr_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  card_det_a_n = '1, card_det_b_n = '1;
    logic [5:0]  pwr_fault_n = '1, slot_switch_n = '1;
    logic [2:0]  slot_count = 3'd6;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int vectors = 0, misses = 0;
    bit done = 0;

    localparam logic [31:0] ALL = 32'h3F3F3F3F;

    always #2 clk = ~clk;

    hp_intr_reg dut (
        .clk(clk), .rst_n(rst_n),
        .card_det_a_n(card_det_a_n), .card_det_b_n(card_det_b_n),
        .pwr_fault_n(pwr_fault_n), .slot_switch_n(slot_switch_n),
        .slot_count(slot_count), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        step(2);
        rd(2'd0, v); check("R1 status in reset", v, 32'h0);
        rd(2'd1, v); check("R1 mask in reset", v, ALL);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        step(4);
        rd(2'd0, v); check("R3 live idle inputs", v, ALL);
        check("R3 no irq while masked", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        wr(2'd1, 32'h0); rd(2'd1, v); check("R7 mask cleared", v, 32'h0);
        wr(2'd1, 32'hFFFFFFFF); rd(2'd1, v); check("R2 mask reserved zero", v, ALL);
        rd(2'd2, v); check("R2 unused address", v, 32'h0);
    endtask

    task automatic t_live();
        logic [31:0] v;
        pwr_fault_n[2] = 1'b0;
        step(4);
        rd(2'd0, v); check("R3 fault slot 2 live", v, ALL & ~32'h400);
        check("R3 masked no irq", {31'b0, irq}, 32'h0);
        pwr_fault_n[2] = 1'b1;
        step(4);
        rd(2'd0, v); check("R3 fault back high", v, ALL);
    endtask

    task automatic t_strap();
        logic [31:0] v;
        slot_count = 3'd3;
        card_det_b_n[2] = 1'b0;
        slot_switch_n[4] = 1'b0;
        step(4);
        rd(2'd0, v); check("R10 slots 3..5 mirror slot 2", v, 32'h3F033F3F);
        slot_count = 3'd0;
        step(4);
        rd(2'd0, v); check("R10 count 0 mirrors slot 0", v, ALL);
        card_det_b_n[2] = 1'b1;
        slot_switch_n[4] = 1'b1;
        slot_count = 3'd6;
        step(4);
        rd(2'd0, v); check("R10 all slots restored", v, ALL);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(2'd1, 32'h0);
        card_det_a_n[0] = 1'b0;
        step(4);
        check("R4 irq on falling change", {31'b0, irq}, 32'h1);
        rd(2'd0, v); check("R4 latched low", v, ALL & ~32'h0100_0000);
        card_det_a_n[0] = 1'b1;
        step(4);
        rd(2'd0, v); check("R5 held while pending", v, ALL & ~32'h0100_0000);
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R6 write 0 keeps value", v, ALL & ~32'h0100_0000);
        check("R6 write 0 keeps irq", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0100_0000);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        rd(2'd0, v); check("R8 reads live after clear", v, ALL);
        step(1);
        check("R8 re-trigger irq", {31'b0, irq}, 32'h1);
        rd(2'd0, v); check("R4 rising level latched", v, ALL);
        wr(2'd0, 32'h0100_0000);
        step(1);
        check("R6 cleared stays clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_irq_or();
        logic [31:0] v;
        slot_switch_n[1] = 1'b0;
        pwr_fault_n[0] = 1'b0;
        step(4);
        check("R11 irq two pending", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0000_0002);
        step(1);
        check("R11 irq one left", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0000_0100);
        step(1);
        check("R11 irq none left", {31'b0, irq}, 32'h0);
        rd(2'd0, v); check("R3 live low after clear", v, ALL & ~32'h0000_0102);
        slot_switch_n[1] = 1'b1;
        pwr_fault_n[0] = 1'b1;
        step(4);
        wr(2'd0, 32'h0000_0102);
        step(1);
        check("R6 restore cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_wins();
        logic [31:0] v;
        pwr_fault_n[5] = 1'b0;
        step(4);
        rd(2'd0, v); check("R4 fault 5 latched", v, ALL & ~32'h2000);
        pwr_fault_n[5] = 1'b1;
        step(2);
        wr(2'd0, 32'h2000);
        check("R9 change beats clear irq", {31'b0, irq}, 32'h1);
        rd(2'd0, v); check("R9 new level latched", v, ALL);
        wr(2'd0, 32'h2000);
        step(1);
        check("R9 final clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask_bit();
        logic [31:0] v;
        wr(2'd1, 32'h0000_0008);
        slot_switch_n[3] = 1'b0;
        step(4);
        check("R7 masked bit no irq", {31'b0, irq}, 32'h0);
        rd(2'd0, v); check("R7 masked bit live", v, ALL & ~32'h8);
        slot_switch_n[2] = 1'b0;
        step(4);
        check("R7 unmasked neighbour fires", {31'b0, irq}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_mask_rw();
        t_live();
        t_strap();
        t_latch();
        t_irq_or();
        t_wins();
        t_mask_bit();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule